// File: doc/BRIEF.md
# Bus Tenure Limit Timer

This block limits how long a bus master may keep ownership of a shared parallel bus during one transaction. Each of two bus interfaces has an 8-bit limit register and a down-counter. The counter is loaded from the register when that interface's master starts a transaction (its frame signal goes active). It then counts clock cycles until it reaches zero. After that it raises an expired flag. When the flag is up and the arbiter has taken the grant away, the block asks the master sequencer to end its tenure.

The two limit registers can be reached from either interface's configuration port. Each register answers at a local offset and at an alias offset. The mapping is mirrored: an interface sees its own limit at the local offset and the other interface's limit at the alias offset. A limit of zero is a special case. The master then gives up the bus only after it has completed at least one data transfer and lost its grant. The block is used inside a two-sided bridge, next to each master sequencer.

Top module: `tenure_timer_top`

## Requirements
- R1: After reset both limit registers read 00h and every expired and relinquish output is 0.
- R2: All 8 bits of each limit register are writable and read back unchanged.
- R3: On configuration side s (0 or 1), offset 0Dh addresses limit register s and offset 4Dh addresses limit register 1-s, for both writes and reads.
- R4: A write to any other offset changes no register, and a read of any other offset returns 00h.
- R5: With limit L, the expired flag of an interface rises at the L-th clock edge after the edge that samples its frame going active. When L=0 it rises at that sampling edge itself.
- R6: Once expired, the flag stays high without wrapping for as long as the frame stays active.
- R7: For L>0, relinquish is high exactly when expired is high and the grant input is low. While the grant is held, relinquish stays low.
- R8: For L=0, relinquish also requires a data-transfer strobe to have been sampled at an edge after the frame start, within the same transaction.
- R9: A register write made during an active transaction does not alter that transaction's timing. The next transaction uses the new value.
- R10: The expired flag clears at the first clock edge that samples the frame as inactive.
- R11: The two interfaces' timers run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_side | input | 1 | Interface issuing the write (0 or 1) |
| cfg_wr_addr | input | 8 | Byte offset of the write |
| cfg_wr_data | input | 8 | Write data |
| cfg_rd_side | input | 1 | Interface issuing the read |
| cfg_rd_addr | input | 8 | Byte offset of the read |
| cfg_rd_data | output | 8 | Read data, combinational |
| frame_act | input | 2 | Per interface: the master's frame is active |
| gnt | input | 2 | Per interface: bus grant held |
| data_done | input | 2 | Per interface: a data phase completed this cycle |
| expired | output | 2 | Per interface: tenure limit reached |
| relinquish | output | 2 | Per interface: request to end the tenure |

## Verification
The bench sweeps every 8-bit limit on one interface and checks the expired and relinquish outputs on each cycle. An off-by-one in the reload or the decrement would move the expiry edge, and a counter that wraps would drop the flag partway through a long transaction. The zero limit is tested with and without a data transfer. A design that treated zero like any other limit would ask for release before any data moved. Writes made during a transaction, writes to every unmapped offset, and the mirrored alias are tested as well. These catch a timer that tracks the live register, a loose address decode, and swapped register copies.

// File: rtl/tenure_timer_pkg.sv
package tenure_timer_pkg;
   // two bus interfaces share the mirrored register map
   localparam int unsigned IF_CNT = 2;

   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;

   // register index selected by a hit on the local or the alias offset
   function automatic logic map_index(input logic side, input logic is_alias);
      return is_alias ? ~side : side;
   endfunction
endpackage

// File: rtl/tenure_limit_regs.sv
module tenure_limit_regs
   import tenure_timer_pkg::*;
#(
   parameter int unsigned        CNT_W     = 8,
   parameter int unsigned        ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]  OFS_LOCAL = 8'h0D,
   parameter logic [ADDR_W-1:0]  OFS_ALIAS = 8'h4D
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          wr_side,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [CNT_W-1:0]              wr_data,
   input  logic                          rd_side,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [CNT_W-1:0]              rd_data,
   output logic [IF_CNT-1:0][CNT_W-1:0]  limit_o
);

   generate
      if (OFS_LOCAL == OFS_ALIAS) begin : g_bad_map
         $error("tenure_limit_regs: local and alias offsets must differ");
      end
   endgenerate

   logic [IF_CNT-1:0][CNT_W-1:0] lim_q;
   logic                         wr_hit_loc, wr_hit_ali, wr_hit;
   logic                         wr_idx;
   logic                         rd_hit_loc, rd_hit_ali;
   logic                         rd_idx;

   always_comb begin
      wr_hit_loc = (wr_addr == OFS_LOCAL);
      wr_hit_ali = (wr_addr == OFS_ALIAS);
      wr_hit     = wr_en & (wr_hit_loc | wr_hit_ali);
      wr_idx     = map_index(wr_side, wr_hit_ali);
   end

   generate
      for (genvar r = 0; r < IF_CNT; r++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lim_q[r] <= '0;
            end else if (wr_hit && (wr_idx == 1'(r))) begin
               lim_q[r] <= wr_data;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_hit_loc = (rd_addr == OFS_LOCAL);
      rd_hit_ali = (rd_addr == OFS_ALIAS);
      rd_idx     = map_index(rd_side, rd_hit_ali);
      if (rd_hit_loc | rd_hit_ali) begin
         rd_data = lim_q[rd_idx];
      end else begin
         rd_data = '0;
      end
   end

   assign limit_o = lim_q;

   // writes that miss both offsets leave the registers alone
   assert_unmapped_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr != OFS_LOCAL) && (wr_addr != OFS_ALIAS)) |=> $stable(lim_q));

   // a write via the alias never touches the writer's own register
   assert_alias_swap_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == OFS_ALIAS) && !wr_side) |=> $stable(lim_q[0]));

endmodule

// File: rtl/tenure_count_engine.sv
module tenure_count_engine #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             frame_i,
   input  logic             gnt_i,
   input  logic             done_i,
   output logic             expired_o,
   output logic             rel_o
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tenure_count_engine: CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             act_q;
   logic             zero_q;
   logic             xfer_q;
   logic [CNT_W-1:0] cnt_q;
   logic             start;
   logic             running;
   logic             at_zero;

   assign start   = frame_i & ~act_q;
   assign running = frame_i & act_q;
   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         zero_q <= 1'b0;
         xfer_q <= 1'b0;
      end else begin
         act_q <= frame_i;
         if (start) begin
            cnt_q  <= limit_i;          // snapshot: later writes wait
            zero_q <= (limit_i == '0);
            xfer_q <= 1'b0;
         end else if (running) begin
            if (!at_zero) begin
               cnt_q <= cnt_q - ONE;    // saturates at zero
            end
            if (done_i) begin
               xfer_q <= 1'b1;
            end
         end else begin
            xfer_q <= 1'b0;
         end
      end
   end

   assign expired_o = act_q & at_zero;
   assign rel_o     = expired_o & ~gnt_i & (~zero_q | xfer_q);

   // frame sampled inactive clears the flag next cycle
   assert_expired_clears_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_i |=> !expired_o);

   // no wrap once expired
   assert_no_wrap_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && frame_i) |=> expired_o);

   // counter steps down by one while running
   assert_count_step_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (running && !at_zero) |=> (cnt_q == $past(cnt_q) - ONE));

   // a fresh tenure is expired at once only for a zero limit
   assert_reload_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (expired_o == ($past(limit_i) == '0)));

endmodule

// File: rtl/tenure_timer_top.sv
module tenure_timer_top
   import tenure_timer_pkg::*;
#(
   parameter int unsigned        CNT_W     = 8,
   parameter int unsigned        ADDR_W    = 8,
   parameter logic [ADDR_W-1:0]  OFS_LOCAL = 8'h0D,
   parameter logic [ADDR_W-1:0]  OFS_ALIAS = 8'h4D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic              cfg_wr_side,
   input  logic [ADDR_W-1:0] cfg_wr_addr,
   input  logic [CNT_W-1:0]  cfg_wr_data,
   input  logic              cfg_rd_side,
   input  logic [ADDR_W-1:0] cfg_rd_addr,
   output logic [CNT_W-1:0]  cfg_rd_data,
   input  logic [1:0]        frame_act,
   input  logic [1:0]        gnt,
   input  logic [1:0]        data_done,
   output logic [1:0]        expired,
   output logic [1:0]        relinquish
);

   generate
      if (IF_CNT != 2) begin : g_bad_ifcnt
         $error("tenure_timer_top: mirrored map needs exactly two interfaces");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("tenure_timer_top: ADDR_W too narrow for the offsets");
      end
   endgenerate

   logic [IF_CNT-1:0][CNT_W-1:0] limit;

   tenure_limit_regs #(
      .CNT_W    (CNT_W),
      .ADDR_W   (ADDR_W),
      .OFS_LOCAL(OFS_LOCAL),
      .OFS_ALIAS(OFS_ALIAS)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .wr_side(cfg_wr_side),
      .wr_addr(cfg_wr_addr),
      .wr_data(cfg_wr_data),
      .rd_side(cfg_rd_side),
      .rd_addr(cfg_rd_addr),
      .rd_data(cfg_rd_data),
      .limit_o(limit)
   );

   generate
      for (genvar i = 0; i < IF_CNT; i++) begin : g_if
         tenure_count_engine #(
            .CNT_W(CNT_W)
         ) u_eng (
            .clk      (clk),
            .rst_n    (rst_n),
            .limit_i  (limit[i]),
            .frame_i  (frame_act[i]),
            .gnt_i    (gnt[i]),
            .done_i   (data_done[i]),
            .expired_o(expired[i]),
            .rel_o    (relinquish[i])
         );

         // grant still held: master keeps the bus
         assert_grant_holds_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            gnt[i] |-> !relinquish[i]);

         // a release request only follows an elapsed limit
         assert_rel_after_expiry_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            relinquish[i] |-> expired[i]);
      end
   endgenerate

endmodule

// File: tb/tenure_timer_top_tb.sv
`timescale 1ns/1ps
module tenure_timer_top_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr_en = 1'b0;
   logic       cfg_wr_side = 1'b0;
   logic [7:0] cfg_wr_addr = '0;
   logic [7:0] cfg_wr_data = '0;
   logic       cfg_rd_side = 1'b0;
   logic [7:0] cfg_rd_addr = '0;
   logic [7:0] cfg_rd_data;
   logic [1:0] frame_act = '0;
   logic [1:0] gnt = '0;
   logic [1:0] data_done = '0;
   logic [1:0] expired;
   logic [1:0] relinquish;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   tenure_timer_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_side(cfg_wr_side),
      .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_side(cfg_rd_side), .cfg_rd_addr(cfg_rd_addr),
      .cfg_rd_data(cfg_rd_data),
      .frame_act(frame_act), .gnt(gnt), .data_done(data_done),
      .expired(expired), .relinquish(relinquish)
   );

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic side, input logic [7:0] addr, input logic [7:0] data);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_side = side; cfg_wr_addr = addr; cfg_wr_data = data;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic cfg_read(input string req, input logic side,
                           input logic [7:0] addr, input logic [7:0] exp);
      cfg_rd_side = side; cfg_rd_addr = addr;
      #1;
      chk(req, "readback", cfg_rd_data, exp);
   endtask

   // one transaction on interface e with limit lim, grant low, a transfer in cycle 0
   task automatic run_tx(input int e, input int lim, input string req);
      @(negedge clk);
      frame_act[e] = 1'b1; gnt[e] = 1'b0;
      for (int k = 0; k <= lim + 2; k++) begin
         @(posedge clk); #2;
         chk(req, "expired", {7'd0, expired[e]}, {7'd0, (k >= lim)});
         chk(req, "relinquish", {7'd0, relinquish[e]},
             {7'd0, (k >= lim) && (lim != 0 || k >= 1)});
         chk("R11", "other expired", {7'd0, expired[1-e]}, 8'd0);
         @(negedge clk);
         data_done[e] = (k == 0);
      end
      frame_act[e] = 1'b0; data_done[e] = 1'b0;
      @(posedge clk); #2;
      chk("R10", "expired after release", {7'd0, expired[e]}, 8'd0);
      chk("R10", "relinquish after release", {7'd0, relinquish[e]}, 8'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1", "expired", {6'd0, expired}, 8'd0);
      chk("R1", "relinquish", {6'd0, relinquish}, 8'd0);
      cfg_read("R1", 1'b0, 8'h0D, 8'h00);
      cfg_read("R1", 1'b0, 8'h4D, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      cfg_read("R1", 1'b1, 8'h0D, 8'h00);
      cfg_read("R1", 1'b1, 8'h4D, 8'h00);

      // R2 every value, both views
      for (int v = 0; v < 256; v++) begin
         cfg_write(1'b0, 8'h0D, 8'(v));
         cfg_read("R2", 1'b0, 8'h0D, 8'(v));
         cfg_read("R3", 1'b1, 8'h4D, 8'(v));
      end

      // R3 mirrored alias
      cfg_write(1'b0, 8'h0D, 8'h11);
      cfg_write(1'b1, 8'h0D, 8'hA5);
      cfg_read("R3", 1'b1, 8'h0D, 8'hA5);
      cfg_read("R3", 1'b0, 8'h4D, 8'hA5);
      cfg_read("R3", 1'b0, 8'h0D, 8'h11);
      cfg_write(1'b0, 8'h4D, 8'h5A);
      cfg_read("R3", 1'b1, 8'h0D, 8'h5A);
      cfg_read("R3", 1'b0, 8'h0D, 8'h11);

      // R4 unmapped offsets
      for (int a = 0; a < 256; a++) begin
         if (a != 8'h0D && a != 8'h4D) begin
            cfg_write(1'(a & 1), 8'(a), 8'hC3);
         end
      end
      cfg_read("R4", 1'b0, 8'h0D, 8'h11);
      cfg_read("R4", 1'b1, 8'h0D, 8'h5A);
      for (int a = 0; a < 256; a++) begin
         if (a != 8'h0D && a != 8'h4D) begin
            cfg_read("R4", 1'(a & 1), 8'(a), 8'h00);
         end
      end

      // R5 R6 R7 R8 sweep of every limit on interface 0
      for (int lim = 0; lim < 256; lim++) begin
         cfg_write(1'b0, 8'h0D, 8'(lim));
         run_tx(0, lim, "R5");
      end
      // R11 interface 1 on its own limits
      for (int lim = 0; lim < 8; lim++) begin
         cfg_write(1'b1, 8'h0D, 8'(lim));
         run_tx(1, lim, "R11");
      end

      // R7 grant held past expiry
      cfg_write(1'b0, 8'h0D, 8'd3);
      @(negedge clk); frame_act[0] = 1'b1; gnt[0] = 1'b1;
      for (int k = 0; k <= 6; k++) begin
         @(posedge clk); #2;
         chk("R6", "expired held", {7'd0, expired[0]}, {7'd0, (k >= 3)});
         chk("R7", "no release with grant", {7'd0, relinquish[0]}, 8'd0);
      end
      @(negedge clk); gnt[0] = 1'b0; #1;
      chk("R7", "release on grant loss", {7'd0, relinquish[0]}, 8'd1);
      frame_act[0] = 1'b0;
      @(posedge clk); #2;
      chk("R10", "expired cleared", {7'd0, expired[0]}, 8'd0);

      // R8 zero limit waits for a transfer
      cfg_write(1'b0, 8'h0D, 8'd0);
      @(negedge clk); frame_act[0] = 1'b1; gnt[0] = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #2;
         chk("R8", "expired", {7'd0, expired[0]}, 8'd1);
         chk("R8", "no transfer yet", {7'd0, relinquish[0]}, 8'd0);
      end
      @(negedge clk); gnt[0] = 1'b1; data_done[0] = 1'b1;
      @(negedge clk); data_done[0] = 1'b0; #1;
      chk("R8", "grant held after transfer", {7'd0, relinquish[0]}, 8'd0);
      gnt[0] = 1'b0; #1;
      chk("R8", "transfer and grant lost", {7'd0, relinquish[0]}, 8'd1);
      frame_act[0] = 1'b0;
      @(posedge clk); #2;
      // new transaction forgets the old transfer
      @(negedge clk); frame_act[0] = 1'b1;
      @(posedge clk); #2;
      chk("R8", "transfer flag cleared", {7'd0, relinquish[0]}, 8'd0);
      @(negedge clk); frame_act[0] = 1'b0;

      // R9 write during a transaction
      cfg_write(1'b0, 8'h0D, 8'd5);
      @(negedge clk); frame_act[0] = 1'b1; gnt[0] = 1'b0;
      @(posedge clk); #2;
      @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_side = 1'b0;
      cfg_wr_addr = 8'h0D; cfg_wr_data = 8'd2;
      for (int k = 1; k <= 6; k++) begin
         @(posedge clk); #2;
         chk("R9", "old limit kept", {7'd0, expired[0]}, {7'd0, (k >= 5)});
         @(negedge clk); cfg_wr_en = 1'b0;
      end
      frame_act[0] = 1'b0;
      @(posedge clk); #2;
      run_tx(0, 2, "R9");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule